// File: doc/BRIEF.md
# Motor-Operated Valve Interlock Controller

This block is a synchronous controller for a single motor-driven valve. Its inputs are field signals (limit feedbacks, thermal protection, local override), interlock lines (availability, per-action authorisations, automatic commands), requests from higher-level logic (priority requests, load shedding, return-to-load) and push buttons (safety stop, mode selector, manual commands, alarm acknowledge). Almost all of these are active-low. From them it drives three registered, active-high commands to the motor starter: open, close and stop.

Demands are resolved through a fixed priority chain. A priority request outranks load shedding and return-to-load. Those outrank the normal automatic or manual command, which must also be authorised by its interlock. Every demand requires the valve to be available and free of faults. When the valve must leave an end position, the controller first holds a stop phase of programmable length and only then issues the travel command.

Each command runs its own travel timer. When a timer runs out and the limit feedback has not confirmed the commanded movement, a latched alarm is raised. Alarms and hard faults combine into an error flag, and the error flag takes the controller out of automatic mode.

Top module: `mov_ctrl`

## Requirements
- R1: During reset and right after it, with no demand present, all three commands, all three alarms, `err_flag` and `auto_mode` are 0.
- R2: `cmd_open` and `cmd_close` are never 1 in the same cycle. While `cmd_stop` is 1, both of them are 0.
- R3: In manual mode (`sel_auto`=1 is automatic, 0 is manual), the valve is available (`avail_n`=0), open is authorised (`open_auth_n`=0), there is no fault and the valve is between end positions (both feedbacks 1). Under these conditions `man_open_n`=0 gives `cmd_open`=1 within 4 cycles, and releasing it drops `cmd_open`.
- R4: A priority stop request (`prio_stop_n`=0) yields `cmd_stop` even when an open demand exists. A priority close request beats a manual open and yields `cmd_close`.
- R5: With `sel_auto`=1 and no error, `auto_mode` becomes 1. In that mode the manual buttons are ignored and `auto_open_n`=0 drives `cmd_open`.
- R6: A fault (`therm_ok`=0, `safety_stop_n`=0 or `local_ovr_n`=0) sets `err_flag`. A fault while the valve is between end positions forces `cmd_stop` and drops travel commands. A fault at an end position leaves all three commands at 0.
- R7: An open demand while the valve is fully closed (`fb_closed_n`=0) first asserts `cmd_stop` for exactly STOP_CYCLES+1 cycles, with `cmd_open`=0. In the cycle after that, `cmd_open` becomes 1.
- R8: If `cmd_open` stays 1 for TRAVEL_CYCLES+1 clock edges without the open feedback (`fb_open_n`=0), `alarm_open` rises on the next edge. `err_flag` follows one cycle later and `auto_mode` falls one cycle after that.
- R9: A set alarm remains 1 until the acknowledge input (`ack_n`=0) is seen with the alarm condition gone. It then clears, and `err_flag` clears unless another cause remains.
- R10: Load shedding (`shed_n`=0) forces `cmd_stop` and blocks open and close demands, including return-to-load. A priority open request overrides shedding.
- R11: A return-to-load open request (`ret_open_n`=0) overrides a manual close and yields `cmd_open`.
- R12: Without availability (`avail_n`=1) or without the matching authorisation (`open_auth_n`=1), a manual open yields no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| therm_ok | input | 1 | Thermal protection, 1 = normal |
| local_ovr_n | input | 1 | Local override, 0 = present |
| safety_stop_n | input | 1 | Safety stop button, 0 = pressed |
| avail_n | input | 1 | Valve availability, 0 = available |
| fb_open_n | input | 1 | Open limit feedback, 0 = fully open |
| fb_closed_n | input | 1 | Close limit feedback, 0 = fully closed |
| open_auth_n | input | 1 | Open authorisation, 0 = authorised |
| close_auth_n | input | 1 | Close authorisation, 0 = authorised |
| stop_auth_n | input | 1 | Stop authorisation, 0 = authorised |
| auto_open_n | input | 1 | Automatic open command, 0 = present |
| auto_close_n | input | 1 | Automatic close command, 0 = present |
| auto_stop_n | input | 1 | Automatic stop command, 0 = present |
| prio_open_n | input | 1 | Priority open request, 0 = present |
| prio_close_n | input | 1 | Priority close request, 0 = present |
| prio_stop_n | input | 1 | Priority stop request, 0 = present |
| shed_n | input | 1 | Load shedding, 0 = requested |
| ret_open_n | input | 1 | Return-to-load open, 0 = requested |
| ret_close_n | input | 1 | Return-to-load close, 0 = requested |
| sel_auto | input | 1 | Mode selector, 1 = automatic |
| man_open_n | input | 1 | Manual open button, 0 = pressed |
| man_close_n | input | 1 | Manual close button, 0 = pressed |
| man_stop_n | input | 1 | Manual stop button, 0 = pressed |
| ack_n | input | 1 | Alarm acknowledge, 0 = pressed |
| cmd_open | output | 1 | Open command to starter |
| cmd_close | output | 1 | Close command to starter |
| cmd_stop | output | 1 | Stop command to starter |
| alarm_open | output | 1 | Latched open travel timeout |
| alarm_close | output | 1 | Latched close travel timeout |
| alarm_stop | output | 1 | Latched contradictory-feedback alarm after stop |
| err_flag | output | 1 | Combined error flag |
| auto_mode | output | 1 | 1 = operating in automatic mode |

## Verification
A wrong command memory or a mis-resolved demand shows up directly on the command outputs. This happens three clock edges after the stimulus: two synchroniser stages and one command register. Such an error appears as a command that is missing, overlapping or held. A wrong travel-timer state shows up as a stop phase of the wrong length, or as an alarm edge one cycle early or late relative to the start of `cmd_open`. A wrong alarm latch shows up as `alarm_open` or `err_flag` clearing without acknowledge, or staying set after it. Either way, `auto_mode` is then affected two cycles later.

// File: rtl/mov_pkg.sv
// Package: shared types and constants of the valve interlock controller.
// Assumes the pin-level struct field set matches the top-level input ports.
package mov_pkg;

    // Timer slots, one per command
    localparam int T_STOP  = 0;
    localparam int T_OPEN  = 1;
    localparam int T_CLOSE = 2;
    localparam int N_TMR   = 3;

    // Inputs as they arrive at the pins (mostly active-low)
    typedef struct packed {
        logic therm_ok;
        logic local_ovr_n;
        logic safety_stop_n;
        logic avail_n;
        logic fb_open_n;
        logic fb_closed_n;
        logic open_auth_n;
        logic close_auth_n;
        logic stop_auth_n;
        logic auto_open_n;
        logic auto_close_n;
        logic auto_stop_n;
        logic prio_open_n;
        logic prio_close_n;
        logic prio_stop_n;
        logic shed_n;
        logic ret_open_n;
        logic ret_close_n;
        logic sel_auto;
        logic man_open_n;
        logic man_close_n;
        logic man_stop_n;
        logic ack_n;
    } mov_raw_t;

    // Synchronised inputs in positive logic: 1 = item present
    typedef struct packed {
        logic thermal_fault;
        logic local_ovr;
        logic safety_stop;
        logic avail;
        logic at_open;
        logic at_closed;
        logic open_auth;
        logic close_auth;
        logic stop_auth;
        logic auto_open;
        logic auto_close;
        logic auto_stop;
        logic prio_open;
        logic prio_close;
        logic prio_stop;
        logic shed;
        logic ret_open;
        logic ret_close;
        logic sel_auto;
        logic man_open;
        logic man_close;
        logic man_stop;
    } mov_req_t;

    // Idle level of every pin, used as synchroniser reset value
    function automatic mov_raw_t raw_idle();
        mov_raw_t r;
        r = '1;
        r.sel_auto = 1'b0;
        return r;
    endfunction

    // Convert pin levels into positive-logic requests
    function automatic mov_req_t decode(input mov_raw_t r);
        mov_req_t q;
        q.thermal_fault = !r.therm_ok;
        q.local_ovr     = !r.local_ovr_n;
        q.safety_stop   = !r.safety_stop_n;
        q.avail         = !r.avail_n;
        q.at_open       = !r.fb_open_n;
        q.at_closed     = !r.fb_closed_n;
        q.open_auth     = !r.open_auth_n;
        q.close_auth    = !r.close_auth_n;
        q.stop_auth     = !r.stop_auth_n;
        q.auto_open     = !r.auto_open_n;
        q.auto_close    = !r.auto_close_n;
        q.auto_stop     = !r.auto_stop_n;
        q.prio_open     = !r.prio_open_n;
        q.prio_close    = !r.prio_close_n;
        q.prio_stop     = !r.prio_stop_n;
        q.shed          = !r.shed_n;
        q.ret_open      = !r.ret_open_n;
        q.ret_close     = !r.ret_close_n;
        q.sel_auto      = r.sel_auto;
        q.man_open      = !r.man_open_n;
        q.man_close     = !r.man_close_n;
        q.man_stop      = !r.man_stop_n;
        return q;
    endfunction

endpackage

// File: rtl/mov_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; resets every stage to RST_VAL so that
// idle levels are seen during and just after reset.
module mov_sync #(
    parameter int             W      = 8,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mov_demand.sv
// Module: combinational demand resolver.
// Ranks priority requests over shedding / return-to-load, and those over
// authorised automatic or manual commands. All demands need availability
// and no fault; a fault between end positions forces a stop demand.
// Assumes inputs are already synchronised and in positive logic.
module mov_demand
    import mov_pkg::*;
(
    input  mov_req_t rq,
    input  logic     auto_mode,
    output logic     fault,
    output logic     moving,
    output logic     stop_dmd,
    output logic     open_dmd,
    output logic     close_dmd
);
    logic ok, no_prio_tr;
    logic want_stop, want_open, want_close;
    logic base_stop, base_open, base_close;
    logic ret_o, ret_c;
    logic lvl_stop, lvl_open, lvl_close;

    // Hard faults and position state
    always_comb begin
        fault  = rq.thermal_fault | rq.local_ovr | rq.safety_stop;
        moving = !rq.at_open && !rq.at_closed;
        ok     = rq.avail && !fault;
    end

    // Pick automatic or manual source; conflicting commands cancel travel
    always_comb begin
        if (auto_mode) begin
            want_stop  = rq.auto_stop;
            want_open  = rq.auto_open  && !rq.auto_stop && !rq.auto_close;
            want_close = rq.auto_close && !rq.auto_stop && !rq.auto_open;
        end else begin
            want_stop  = rq.man_stop;
            want_open  = rq.man_open  && !rq.man_stop && !rq.man_close;
            want_close = rq.man_close && !rq.man_stop && !rq.man_open;
        end
    end

    // Interlock authorisation and return-to-load masking of the base commands
    always_comb begin
        base_stop  = want_stop  && rq.stop_auth && !rq.ret_open && !rq.ret_close;
        base_open  = want_open  && rq.open_auth && !rq.ret_close;
        base_close = want_close && rq.close_auth && !rq.ret_open;
        ret_o      = rq.ret_open  && !rq.ret_close;
        ret_c      = rq.ret_close && !rq.ret_open;
    end

    // Priority layer: priority stop > priority travel > shedding > return > base
    always_comb begin
        no_prio_tr = !rq.prio_open && !rq.prio_close;
        lvl_stop   = rq.prio_stop || (no_prio_tr && (rq.shed || base_stop));
        lvl_open   = !rq.prio_stop &&
                     ((rq.prio_open && !rq.prio_close) ||
                      (no_prio_tr && !rq.shed && (ret_o || base_open)));
        lvl_close  = !rq.prio_stop &&
                     ((rq.prio_close && !rq.prio_open) ||
                      (no_prio_tr && !rq.shed && (ret_c || base_close)));
    end

    // Final gating by availability and faults
    always_comb begin
        stop_dmd  = (lvl_stop && ok) || (fault && moving);
        open_dmd  = lvl_open && ok;
        close_dmd = lvl_close && ok;
    end
endmodule

// File: rtl/mov_timer.sv
// Module: travel timer with latched timeout alarm.
// Counts cycles while run is 1 and saturates at LIMIT; held at zero while
// run is 0. The alarm sets when the timer has expired and miss is 1, and
// clears only on ack with no set condition. Assumes LIMIT >= 1.
module mov_timer #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic miss,
    input  logic ack,
    output logic expired,
    output logic alarm
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Count while the command is active, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LIM_V) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIM_V);

    // Latch the timeout alarm until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)               alarm <= 1'b0;
        else if (expired && miss) alarm <= 1'b1;
        else if (ack)             alarm <= 1'b0;
    end
endmodule

// File: rtl/mov_ctrl.sv
// Module: motor-operated valve interlock controller (top).
// Synchronises all pins, resolves demands, sequences a stop phase before
// leaving an end position, runs one travel timer per command, latches
// timeout alarms and derives the error flag and operating mode.
// Assumes one valve, limit feedbacks active-low, commands active-high.
module mov_ctrl
    import mov_pkg::*;
#(
    parameter int STOP_CYCLES   = 50000,
    parameter int TRAVEL_CYCLES = 2000000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic therm_ok,
    input  logic local_ovr_n,
    input  logic safety_stop_n,
    input  logic avail_n,
    input  logic fb_open_n,
    input  logic fb_closed_n,
    input  logic open_auth_n,
    input  logic close_auth_n,
    input  logic stop_auth_n,
    input  logic auto_open_n,
    input  logic auto_close_n,
    input  logic auto_stop_n,
    input  logic prio_open_n,
    input  logic prio_close_n,
    input  logic prio_stop_n,
    input  logic shed_n,
    input  logic ret_open_n,
    input  logic ret_close_n,
    input  logic sel_auto,
    input  logic man_open_n,
    input  logic man_close_n,
    input  logic man_stop_n,
    input  logic ack_n,
    output logic cmd_open,
    output logic cmd_close,
    output logic cmd_stop,
    output logic alarm_open,
    output logic alarm_close,
    output logic alarm_stop,
    output logic err_flag,
    output logic auto_mode
);
    localparam int RAW_W  = $bits(mov_raw_t);
    localparam int MAXLIM = (STOP_CYCLES > TRAVEL_CYCLES) ? STOP_CYCLES : TRAVEL_CYCLES;
    localparam int CNT_W  = $clog2(MAXLIM + 1);
    localparam mov_raw_t RAW_IDLE = raw_idle();

    mov_raw_t         raw_pin, raw_s;
    logic [RAW_W-1:0] raw_s_v;
    mov_req_t         rq;
    logic             ack_s;

    logic fault_s, moving_s, sd, od, cd;
    logic cmd_open_q, cmd_close_q, cmd_stop_q, err_q, auto_q;
    logic nx_open, nx_close, nx_stop;
    logic cm_any, cm_open, st_any, st_open, stop_done;
    logic [N_TMR-1:0] t_run, t_miss, t_exp, t_alarm;

    // Gather the pins into one vector for synchronisation
    always_comb begin
        raw_pin.therm_ok      = therm_ok;
        raw_pin.local_ovr_n   = local_ovr_n;
        raw_pin.safety_stop_n = safety_stop_n;
        raw_pin.avail_n       = avail_n;
        raw_pin.fb_open_n     = fb_open_n;
        raw_pin.fb_closed_n   = fb_closed_n;
        raw_pin.open_auth_n   = open_auth_n;
        raw_pin.close_auth_n  = close_auth_n;
        raw_pin.stop_auth_n   = stop_auth_n;
        raw_pin.auto_open_n   = auto_open_n;
        raw_pin.auto_close_n  = auto_close_n;
        raw_pin.auto_stop_n   = auto_stop_n;
        raw_pin.prio_open_n   = prio_open_n;
        raw_pin.prio_close_n  = prio_close_n;
        raw_pin.prio_stop_n   = prio_stop_n;
        raw_pin.shed_n        = shed_n;
        raw_pin.ret_open_n    = ret_open_n;
        raw_pin.ret_close_n   = ret_close_n;
        raw_pin.sel_auto      = sel_auto;
        raw_pin.man_open_n    = man_open_n;
        raw_pin.man_close_n   = man_close_n;
        raw_pin.man_stop_n    = man_stop_n;
        raw_pin.ack_n         = ack_n;
    end

    mov_sync #(
        .W(RAW_W), .STAGES(SYNC_STAGES), .RST_VAL(RAW_IDLE)
    ) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_pin), .q(raw_s_v)
    );

    // Decode synchronised pins into positive logic
    always_comb begin
        raw_s = mov_raw_t'(raw_s_v);
        rq    = decode(raw_s);
        ack_s = !raw_s.ack_n;
    end

    mov_demand i_dmd (
        .rq(rq), .auto_mode(auto_q), .fault(fault_s), .moving(moving_s),
        .stop_dmd(sd), .open_dmd(od), .close_dmd(cd)
    );

    // Command and status memory bits
    always_comb begin
        cm_any  = cmd_open_q || cmd_close_q;
        cm_open = cm_any && cmd_open_q;
        st_any  = rq.at_open || rq.at_closed;
        st_open = st_any && rq.at_open;
    end

    // Timer run and mismatch conditions per command
    always_comb begin
        t_run[T_STOP]   = cmd_stop_q;
        t_run[T_OPEN]   = cmd_open_q;
        t_run[T_CLOSE]  = cmd_close_q;
        t_miss[T_OPEN]  = cm_open && !st_open;
        t_miss[T_CLOSE] = cm_any && !cm_open && !(st_any && !st_open);
        t_miss[T_STOP]  = st_open && rq.at_closed;
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam int LIM = (g == T_STOP) ? STOP_CYCLES : TRAVEL_CYCLES;
        mov_timer #(.CNT_W(CNT_W), .LIMIT(LIM)) i_tmr (
            .clk(clk), .rst_n(rst_n), .run(t_run[g]), .miss(t_miss[g]),
            .ack(ack_s), .expired(t_exp[g]), .alarm(t_alarm[g])
        );
    end

    assign stop_done = t_exp[T_STOP];

    // Next commands: stop phase precedes travel away from an end position
    always_comb begin
        nx_stop  = sd ||
                   (cd && rq.at_open   && !cmd_close_q && !stop_done) ||
                   (od && rq.at_closed && !cmd_open_q  && !stop_done);
        nx_open  = od && !sd && (cmd_open_q  || !rq.at_closed || stop_done);
        nx_close = cd && !sd && (cmd_close_q || !rq.at_open   || stop_done);
    end

    // Registered commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_open_q  <= 1'b0;
            cmd_close_q <= 1'b0;
            cmd_stop_q  <= 1'b0;
        end else begin
            cmd_open_q  <= nx_open;
            cmd_close_q <= nx_close;
            cmd_stop_q  <= nx_stop;
        end
    end

    // Error flag and operating mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            err_q  <= (|t_alarm) || fault_s;
            auto_q <= rq.sel_auto && !err_q;
        end
    end

    assign cmd_open    = cmd_open_q;
    assign cmd_close   = cmd_close_q;
    assign cmd_stop    = cmd_stop_q;
    assign alarm_open  = t_alarm[T_OPEN];
    assign alarm_close = t_alarm[T_CLOSE];
    assign alarm_stop  = t_alarm[T_STOP];
    assign err_flag    = err_q;
    assign auto_mode   = auto_q;
endmodule

// File: rtl/mov_ctrl_chk.sv
// Module: assertion checker for mov_ctrl, attached by bind.
// Assumes access to the synchronised acknowledge, fault and position state.
module mov_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_open,
    input logic cmd_close,
    input logic cmd_stop,
    input logic alarm_open,
    input logic err_flag,
    input logic auto_mode,
    input logic ack_s,
    input logic fault_s,
    input logic moving_s
);
    // R2: travel commands mutually exclusive
    p_open_close_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_open && cmd_close));

    // R2: stop excludes travel
    p_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |-> (!cmd_open && !cmd_close));

    // R6: fault between ends forces stop next cycle
    p_fault_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_s && moving_s) |=> (cmd_stop && !cmd_open && !cmd_close));

    // R8: error leaves automatic mode
    p_err_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !auto_mode);

    // R9: alarm holds without acknowledge
    p_alarm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_open && !ack_s) |=> alarm_open);

    // R9: an alarm keeps the error flag set
    p_alarm_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_open |=> err_flag);
endmodule

bind mov_ctrl mov_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_open(cmd_open), .cmd_close(cmd_close),
    .cmd_stop(cmd_stop), .alarm_open(alarm_open), .err_flag(err_flag),
    .auto_mode(auto_mode), .ack_s(ack_s), .fault_s(fault_s), .moving_s(moving_s)
);

// File: tb/test_mov_ctrl.sv
// Directed bench for mov_ctrl: one task per scenario, each self-checking.
module test_mov_ctrl;
    localparam int STOP   = 4;
    localparam int TRAVEL = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic therm_ok, local_ovr_n, safety_stop_n, avail_n, fb_open_n, fb_closed_n;
    logic open_auth_n, close_auth_n, stop_auth_n;
    logic auto_open_n, auto_close_n, auto_stop_n;
    logic prio_open_n, prio_close_n, prio_stop_n, shed_n, ret_open_n, ret_close_n;
    logic sel_auto, man_open_n, man_close_n, man_stop_n, ack_n;
    logic cmd_open, cmd_close, cmd_stop, alarm_open, alarm_close, alarm_stop;
    logic err_flag, auto_mode;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mov_ctrl #(.STOP_CYCLES(STOP), .TRAVEL_CYCLES(TRAVEL)) i_mov_ctrl (
        .clk(clk), .rst_n(rst_n), .therm_ok(therm_ok), .local_ovr_n(local_ovr_n),
        .safety_stop_n(safety_stop_n), .avail_n(avail_n), .fb_open_n(fb_open_n),
        .fb_closed_n(fb_closed_n), .open_auth_n(open_auth_n), .close_auth_n(close_auth_n),
        .stop_auth_n(stop_auth_n), .auto_open_n(auto_open_n), .auto_close_n(auto_close_n),
        .auto_stop_n(auto_stop_n), .prio_open_n(prio_open_n), .prio_close_n(prio_close_n),
        .prio_stop_n(prio_stop_n), .shed_n(shed_n), .ret_open_n(ret_open_n),
        .ret_close_n(ret_close_n), .sel_auto(sel_auto), .man_open_n(man_open_n),
        .man_close_n(man_close_n), .man_stop_n(man_stop_n), .ack_n(ack_n),
        .cmd_open(cmd_open), .cmd_close(cmd_close), .cmd_stop(cmd_stop),
        .alarm_open(alarm_open), .alarm_close(alarm_close), .alarm_stop(alarm_stop),
        .err_flag(err_flag), .auto_mode(auto_mode)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic defaults();
        therm_ok = 1; local_ovr_n = 1; safety_stop_n = 1; avail_n = 0;
        fb_open_n = 1; fb_closed_n = 1;
        open_auth_n = 0; close_auth_n = 0; stop_auth_n = 0;
        auto_open_n = 1; auto_close_n = 1; auto_stop_n = 1;
        prio_open_n = 1; prio_close_n = 1; prio_stop_n = 1; shed_n = 1;
        ret_open_n = 1; ret_close_n = 1;
        sel_auto = 0; man_open_n = 1; man_close_n = 1; man_stop_n = 1; ack_n = 1;
    endtask

    task automatic do_reset();
        defaults();
        rst_n = 0;
        step(3);
        rst_n = 1;
        step(5);
    endtask

    function automatic int outs();
        return {cmd_open, cmd_close, cmd_stop, alarm_open, alarm_close,
                alarm_stop, err_flag, auto_mode};
    endfunction

    task automatic t_reset();
        defaults();
        rst_n = 0;
        step(3);
        chk("R1 outputs in reset", outs(), 0);
        rst_n = 1;
        step(5);
        chk("R1 outputs after reset", outs(), 0);
    endtask

    task automatic t_manual_open();
        do_reset();
        man_open_n = 0;
        step(4);
        chk("R3 open from mid", cmd_open, 1);
        chk("R2 close off", cmd_close, 0);
        chk("R2 stop off", cmd_stop, 0);
        man_open_n = 1;
        step(4);
        chk("R3 open released", cmd_open, 0);
    endtask

    task automatic t_priority();
        do_reset();
        man_open_n = 0; prio_stop_n = 0;
        step(5);
        chk("R4 prio stop stops", cmd_stop, 1);
        chk("R4 prio stop blocks open", cmd_open, 0);
        prio_stop_n = 1; prio_close_n = 0;
        step(5);
        chk("R4 prio close beats manual open", cmd_close, 1);
        chk("R2 no open with close", cmd_open, 0);
    endtask

    task automatic t_shed();
        do_reset();
        man_open_n = 0; shed_n = 0;
        step(5);
        chk("R10 shed forces stop", cmd_stop, 1);
        chk("R10 shed blocks open", cmd_open, 0);
        man_open_n = 1; ret_open_n = 0;
        step(5);
        chk("R10 shed blocks return open", cmd_open, 0);
        prio_open_n = 0;
        step(5);
        chk("R10 prio open over shed", cmd_open, 1);
        chk("R10 stop released", cmd_stop, 0);
    endtask

    task automatic t_return();
        do_reset();
        man_close_n = 0; ret_open_n = 0;
        step(5);
        chk("R11 return open beats manual close", cmd_open, 1);
        chk("R11 no close", cmd_close, 0);
    endtask

    task automatic t_gating();
        do_reset();
        avail_n = 1; man_open_n = 0;
        step(5);
        chk("R12 unavailable no command", {cmd_open, cmd_close, cmd_stop}, 0);
        avail_n = 0; open_auth_n = 1;
        step(5);
        chk("R12 unauthorised no open", cmd_open, 0);
    endtask

    task automatic t_auto();
        do_reset();
        sel_auto = 1; man_open_n = 0;
        step(5);
        chk("R5 auto mode entered", auto_mode, 1);
        chk("R5 manual ignored in auto", cmd_open, 0);
        auto_open_n = 0;
        step(5);
        chk("R5 auto open drives open", cmd_open, 1);
    endtask

    task automatic t_fault();
        do_reset();
        man_open_n = 0;
        step(5);
        safety_stop_n = 0;
        step(5);
        chk("R6 fault mid forces stop", cmd_stop, 1);
        chk("R6 fault drops open", cmd_open, 0);
        chk("R6 fault sets error", err_flag, 1);
        fb_closed_n = 0;
        step(5);
        chk("R6 fault at end no command", {cmd_open, cmd_close, cmd_stop}, 0);
    endtask

    task automatic t_end_start();
        int n;
        int bad;
        do_reset();
        fb_closed_n = 0; man_open_n = 0;
        n = 0;
        while (!cmd_stop && n < 20) begin n++; step(1); end
        chk("R7 stop phase starts", cmd_stop, 1);
        n = 0; bad = 0;
        while (cmd_stop && n < 50) begin
            if (cmd_open) bad++;
            n++;
            step(1);
        end
        chk("R7 stop phase length", n, STOP + 1);
        chk("R2 no open during stop", bad, 0);
        chk("R7 open after stop", cmd_open, 1);
    endtask

    task automatic t_alarm();
        int n;
        do_reset();
        sel_auto = 1; auto_open_n = 0;
        n = 0;
        while (!cmd_open && n < 20) begin n++; step(1); end
        chk("R8 open started", cmd_open, 1);
        step(TRAVEL);
        chk("R8 no alarm before timeout", alarm_open, 0);
        step(1);
        chk("R8 alarm on timeout", alarm_open, 1);
        step(1);
        chk("R8 error follows alarm", err_flag, 1);
        step(1);
        chk("R8 auto mode dropped", auto_mode, 0);
        step(1);
        chk("R8 open dropped in manual", cmd_open, 0);
        step(10);
        chk("R9 alarm held without ack", alarm_open, 1);
        chk("R9 error held without ack", err_flag, 1);
        auto_open_n = 1; ack_n = 0;
        step(5);
        chk("R9 alarm cleared by ack", alarm_open, 0);
        chk("R9 error cleared", err_flag, 0);
        ack_n = 1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_manual_open();
        t_priority();
        t_shed();
        t_return();
        t_gating();
        t_auto();
        t_fault();
        t_end_start();
        t_alarm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule